// File: doc/BRIEF.md
# Maskable Status Interrupt Controller

This block keeps the status flags of a network node together with an interrupt enable register, and drives one interrupt line toward the host. The protocol core reports events in two ways. Reconfiguration timeouts, excessive NAKs and a new next-node ID arrive as single-cycle pulses, and these latch sticky flags. Receiver-inhibited and transmitter-available arrive as live levels and are not stored.

The host uses a small register port. It reads the status, writes and reads the enable mask, issues clear commands, and reads the next-node ID. Each sticky flag has its own way to clear. The general clear command empties the reconfiguration flag. The power-on clear command empties the reconfiguration and excessive-NAK flags. Reading the next-ID register empties the new-next-ID flag. Masking a source hides its interrupt but never clears the flag behind it.

The reset input is asserted asynchronously and is expected to be released in step with the clock by the surrounding reset logic.

Top module: `stat_irq_ctrl`

## Requirements
- R1: A read strobe loads `host_rdata` at the next clock edge, and the value holds until the next read. Address 0 returns status: bit 7 receiver-inhibited (live), bit 3 new-next-ID, bit 2 reconfiguration, bit 1 excessive-NAK, bit 0 transmitter-available (live). All other status bits read 0.
- R2: Address 1 is the enable mask. It reads back what was written ANDed with 0x8F. A 1 in a bit enables the status bit at the same position. Writing 1 to bits 6..4 has no effect on the interrupt.
- R3: `irq` is a register. After each clock edge it equals the OR over all bits of (status AND mask) as they stood just before that edge.
- R4: The receiver-inhibited and transmitter-available sources are not stored. Clearing their mask bit removes the interrupt. Setting the mask bit again brings the interrupt back while the level is still high. The interrupt drops one cycle after the level falls.
- R5: A pulse on `ev_recon` sets the reconfiguration flag. A write to address 2 with bit 0 (general clear) or bit 1 (power-on clear) set clears it.
- R6: A pulse on `ev_exnak` sets the excessive-NAK flag. Only a write to address 2 with bit 1 set clears it. A command with only bit 0 set leaves it unchanged.
- R7: A pulse on `ev_newnx` sets the new-next-ID flag. A read of address 3 returns `next_id` and clears the flag. Reads of other addresses leave it unchanged.
- R8: When a set pulse and a clear of the same flag land in the same cycle, the flag ends up set.
- R9: After reset the flags, the mask, `irq` and `host_rdata` are all 0.
- R10: Writes to addresses 0 and 3 change no state. A read of address 2 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ev_recon | input | 1 | Reconfiguration timeout event pulse |
| ev_exnak | input | 1 | Excessive-NAK event pulse |
| ev_newnx | input | 1 | New next-node ID event pulse |
| lvl_rxinh | input | 1 | Receiver-inhibited live level |
| lvl_txav | input | 1 | Transmitter-available live level |
| next_id | input | 8 | Current next-node ID from the core |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| irq | output | 1 | Registered active-high interrupt |

## Verification
A sticky flag's set event can land in the same cycle as the host action that clears it. This means a recon pulse with a clear command, an excessive-NAK pulse with a power-on clear, or a new-ID pulse with a next-ID read. The bench drives each pair together on purpose, and a pseudo-random phase also lets such pairs meet by chance. The bench's behavioural model applies the set after the clear. Every cycle, the model's `irq` and read data are compared with the design's, so a lost event shows up as a status bit or interrupt that is missing one edge later.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  // status / mask bit positions (mask bit n enables status bit n)
  localparam int BIT_TXAV  = 0;
  localparam int BIT_EXNAK = 1;
  localparam int BIT_RECON = 2;
  localparam int BIT_NEWNX = 3;
  localparam int BIT_RXINH = 7;
  localparam logic [DATA_W-1:0] DEF_MASK = 8'h8F;

  // command bits written to the command address
  localparam int CMD_GEN = 0;
  localparam int CMD_POR = 1;

  // sticky flag indices
  localparam int SF_RECON  = 0;
  localparam int SF_EXNAK  = 1;
  localparam int SF_NEWNX  = 2;
  localparam int NUM_STICKY = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 2'd0,
    A_MASK = 2'd1,
    A_CMD  = 2'd2,
    A_NXID = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  logic [N-1:0] q_nxt;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // set takes priority so an event coinciding with a clear survives
    always_comb begin
      q_nxt[i] = set_i[i] | (q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= 1'b0;
      end else begin
        q[i] <= q_nxt[i];
      end
    end
  end
endmodule

// File: rtl/host_regs.sv
module host_regs
  import stat_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NS = NUM_STICKY
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] next_id,
  output logic [DW-1:0] mask_q,
  output logic [NS-1:0] clr,
  output logic [DW-1:0] rdata
);
  logic          cmd_wr;
  logic          mask_we;
  logic [DW-1:0] mask_nxt;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_nxt;

  always_comb begin
    cmd_wr   = wr && (addr == A_CMD);
    mask_we  = wr && (addr == A_MASK);
    mask_nxt = mask_we ? (wdata & DEF_MASK) : mask_q;

    clr            = '0;
    clr[SF_RECON]  = cmd_wr && (wdata[CMD_GEN] || wdata[CMD_POR]);
    clr[SF_EXNAK]  = cmd_wr && wdata[CMD_POR];
    clr[SF_NEWNX]  = rd && (addr == A_NXID);

    case (addr)
      A_STAT:  rd_mux = status;
      A_MASK:  rd_mux = mask_q;
      A_NXID:  rd_mux = next_id;
      default: rd_mux = '0;
    endcase
    rdata_nxt = rd ? rd_mux : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rdata  <= '0;
    end else begin
      mask_q <= mask_nxt;
      rdata  <= rdata_nxt;
    end
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] mask,
  output logic          irq_q
);
  logic irq_nxt;

  always_comb begin
    irq_nxt = |(status & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_nxt;
    end
  end
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_recon,
  input  logic              ev_exnak,
  input  logic              ev_newnx,
  input  logic              lvl_rxinh,
  input  logic              lvl_txav,
  input  logic [DATA_W-1:0] next_id,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq
);
  logic [NUM_STICKY-1:0] flag_set;
  logic [NUM_STICKY-1:0] flag_clr;
  logic [NUM_STICKY-1:0] flag_q;
  logic [DATA_W-1:0]     status;
  logic [DATA_W-1:0]     mask_q;

  always_comb begin
    flag_set           = '0;
    flag_set[SF_RECON] = ev_recon;
    flag_set[SF_EXNAK] = ev_exnak;
    flag_set[SF_NEWNX] = ev_newnx;

    status             = '0;
    status[BIT_TXAV]   = lvl_txav;
    status[BIT_RXINH]  = lvl_rxinh;
    status[BIT_RECON]  = flag_q[SF_RECON];
    status[BIT_EXNAK]  = flag_q[SF_EXNAK];
    status[BIT_NEWNX]  = flag_q[SF_NEWNX];
  end

  sticky_flags #(.N(NUM_STICKY)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q     (flag_q)
  );

  host_regs #(.DW(DATA_W), .AW(ADDR_W), .NS(NUM_STICKY)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (host_wr),
    .rd      (host_rd),
    .addr    (host_addr),
    .wdata   (host_wdata),
    .status  (status),
    .next_id (next_id),
    .mask_q  (mask_q),
    .clr     (flag_clr),
    .rdata   (host_rdata)
  );

  irq_merge #(.DW(DATA_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status),
    .mask   (mask_q),
    .irq_q  (irq)
  );
endmodule

// File: rtl/stat_irq_ctrl_chk.sv
module stat_irq_ctrl_chk
  import stat_irq_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ev_recon,
  input logic                  ev_exnak,
  input logic                  ev_newnx,
  input logic                  lvl_rxinh,
  input logic                  host_wr,
  input logic                  host_rd,
  input logic [ADDR_W-1:0]     host_addr,
  input logic [DATA_W-1:0]     host_wdata,
  input logic [DATA_W-1:0]     host_rdata,
  input logic                  irq,
  input logic [DATA_W-1:0]     mask_q,
  input logic [NUM_STICKY-1:0] flag_q
);
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_MASK) |=> (mask_q == ($past(host_wdata) & DEF_MASK)));

  p_irq_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq);

  p_rxinh_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_rxinh && mask_q[BIT_RXINH]) |=> irq);

  p_recon_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_CMD && (host_wdata[CMD_GEN] || host_wdata[CMD_POR]) && !ev_recon)
      |=> !flag_q[SF_RECON]);

  p_exnak_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[SF_EXNAK] && !(host_wr && host_addr == A_CMD && host_wdata[CMD_POR]))
      |=> flag_q[SF_EXNAK]);

  p_newnx_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_NXID && !ev_newnx) |=> !flag_q[SF_NEWNX]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_recon || ev_exnak) |=> (flag_q[SF_RECON] || flag_q[SF_EXNAK]));
endmodule

bind stat_irq_ctrl stat_irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_recon   (ev_recon),
  .ev_exnak   (ev_exnak),
  .ev_newnx   (ev_newnx),
  .lvl_rxinh  (lvl_rxinh),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .irq        (irq),
  .mask_q     (mask_q),
  .flag_q     (flag_q)
);

// File: tb/stat_irq_ctrl_bench.sv
module stat_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_recon = 1'b0, ev_exnak = 1'b0, ev_newnx = 1'b0;
  logic       lvl_rxinh = 1'b0, lvl_txav = 1'b0;
  logic [7:0] next_id = 8'h00;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       irq;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_tag = "R9";

  // reference state
  logic       m_rc, m_ex, m_nn, m_irq;
  logic [7:0] m_mask, m_rdata;

  always #10 clk = ~clk; // 50 MHz

  stat_irq_ctrl u_stat_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_recon(ev_recon), .ev_exnak(ev_exnak),
    .ev_newnx(ev_newnx), .lvl_rxinh(lvl_rxinh), .lvl_txav(lvl_txav),
    .next_id(next_id), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  function automatic logic [7:0] m_status();
    return {lvl_rxinh, 3'b000, m_nn, m_rc, m_ex, lvl_txav};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rc = 0; m_ex = 0; m_nn = 0; m_irq = 0; m_mask = 0; m_rdata = 0;
    end else begin
      logic clr_rc, clr_ex, clr_nn;
      m_irq = |(m_status() & m_mask);
      if (host_rd) begin
        case (host_addr)
          2'd0: m_rdata = m_status();
          2'd1: m_rdata = m_mask;
          2'd3: m_rdata = next_id;
          default: m_rdata = 8'h00;
        endcase
      end
      clr_rc = host_wr && host_addr == 2'd2 && (host_wdata[0] || host_wdata[1]);
      clr_ex = host_wr && host_addr == 2'd2 && host_wdata[1];
      clr_nn = host_rd && host_addr == 2'd3;
      if (clr_rc) m_rc = 0;
      if (clr_ex) m_ex = 0;
      if (clr_nn) m_nn = 0;
      if (ev_recon) m_rc = 1;
      if (ev_exnak) m_ex = 1;
      if (ev_newnx) m_nn = 1;
      if (host_wr && host_addr == 2'd1) m_mask = host_wdata & 8'h8F;
    end
  end

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check8({7'd0, irq}, {7'd0, m_irq}, {cur_tag, " irq"});
    check8(host_rdata, m_rdata, {cur_tag, " rdata"});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    tick();
    host_wr = 0; host_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    host_rd = 1; host_addr = a;
    tick();
    host_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    // R9: reset state
    repeat (3) @(negedge clk);
    check8({7'd0, irq}, 8'h00, "R9 irq in reset");
    check8(host_rdata, 8'h00, "R9 rdata in reset");
    rst_n = 1;
    tick();
    rd(2'd1); check8(host_rdata, 8'h00, "R9 mask after reset");
    rd(2'd0); check8(host_rdata, 8'h00, "R9 status after reset");

    // R2: mask storage and undefined bits
    cur_tag = "R2";
    wr(2'd1, 8'hFF); rd(2'd1); check8(host_rdata, 8'h8F, "R2 mask readback");
    wr(2'd1, 8'h70); tick(); tick(); check8({7'd0, irq}, 8'h00, "R2 undefined mask bits");

    // R10: writes to status / next-ID do nothing; command read is 0
    cur_tag = "R10";
    wr(2'd0, 8'hFF); wr(2'd3, 8'hFF); rd(2'd0); check8(host_rdata, 8'h00, "R10 status write ignored");
    rd(2'd1); check8(host_rdata, 8'h00, "R10 mask untouched");
    rd(2'd2); check8(host_rdata, 8'h00, "R10 command read");

    // R4: live level sources
    cur_tag = "R4";
    wr(2'd1, 8'h81); lvl_txav = 1; tick(); tick();
    check8({7'd0, irq}, 8'h01, "R4 txav raises irq");
    wr(2'd1, 8'h80); tick(); check8({7'd0, irq}, 8'h00, "R4 txav masked");
    wr(2'd1, 8'h81); tick(); check8({7'd0, irq}, 8'h01, "R4 txav reappears");
    lvl_txav = 0; lvl_rxinh = 1; tick(); tick();
    check8({7'd0, irq}, 8'h01, "R4 rxinh raises irq");
    lvl_rxinh = 0; tick(); tick(); check8({7'd0, irq}, 8'h00, "R4 rxinh drop");

    // R5: reconfiguration flag
    cur_tag = "R5";
    wr(2'd1, 8'h04);
    ev_recon = 1; tick(); ev_recon = 0; tick();
    check8({7'd0, irq}, 8'h01, "R5 recon irq");
    wr(2'd2, 8'h01); tick(); check8({7'd0, irq}, 8'h00, "R5 general clear");
    ev_recon = 1; tick(); ev_recon = 0;
    wr(2'd2, 8'h02); rd(2'd0); check8(host_rdata, 8'h00, "R5 power-on clear");

    // R6: excessive-NAK flag
    cur_tag = "R6";
    wr(2'd1, 8'h02);
    ev_exnak = 1; tick(); ev_exnak = 0;
    wr(2'd2, 8'h01); rd(2'd0); check8(host_rdata, 8'h02, "R6 survives general clear");
    wr(2'd2, 8'h02); rd(2'd0); check8(host_rdata, 8'h00, "R6 power-on clear");

    // R7: new-next-ID flag
    cur_tag = "R7";
    wr(2'd1, 8'h08); next_id = 8'h5A;
    ev_newnx = 1; tick(); ev_newnx = 0;
    rd(2'd0); check8(host_rdata, 8'h08, "R7 status read keeps flag");
    rd(2'd3); check8(host_rdata, 8'h5A, "R7 next-ID value");
    rd(2'd0); check8(host_rdata, 8'h00, "R7 cleared by next-ID read");

    // R8: set and clear in the same cycle
    cur_tag = "R8";
    ev_recon = 1; ev_exnak = 1; wr(2'd2, 8'h02); ev_recon = 0; ev_exnak = 0;
    rd(2'd0); check8(host_rdata, 8'h06, "R8 set beats command clear");
    ev_newnx = 1; rd(2'd3); ev_newnx = 0;
    rd(2'd0); check8(host_rdata, 8'h0E, "R8 set beats read clear");

    // R1: full status layout
    cur_tag = "R1";
    lvl_rxinh = 1; lvl_txav = 1; rd(2'd0); check8(host_rdata, 8'h8F, "R1 status layout");
    tick(); check8(host_rdata, 8'h8F, "R1 rdata holds");
    lvl_rxinh = 0; lvl_txav = 0;
    wr(2'd2, 8'h03); rd(2'd3);

    // R3: pseudo-random traffic against the model
    cur_tag = "R3";
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ev_recon   = (lfsr[2:0] == 3'd1);
      ev_exnak   = (lfsr[5:3] == 3'd2);
      ev_newnx   = (lfsr[8:6] == 3'd3);
      lvl_rxinh  = lfsr[9] & lfsr[4];
      lvl_txav   = lfsr[10];
      next_id    = lfsr[15:8];
      host_addr  = lfsr[12:11];
      host_wr    = (lfsr[14:13] == 2'd0);
      host_rd    = (lfsr[14:13] == 2'd1);
      host_wdata = lfsr[7:0] ^ lfsr[15:8];
      tick();
    end
    {ev_recon, ev_exnak, ev_newnx, lvl_rxinh, lvl_txav, host_wr, host_rd} = '0;
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule